// File: doc/BRIEF.md
# Serial flash command sequencer

This block runs one serial-flash access on a half-duplex SPI bus for each write to its command register. An accepted command drives a fixed phase order onto the wire: an opcode byte, zero to four address bytes taken from the address register with the most significant byte first, zero to fifteen dummy bytes, and zero to four data bytes. The data bytes are either sent from the data register or received into it. Every byte is shifted most significant bit first. The clock idles high and the slave's output is sampled on the rising edge, which is SPI mode 3.

A per-command flag keeps the chip select asserted after the command ends. A long flash transaction can then be built from several short commands. A command that continues a held transaction does not send the opcode again. A continuation that carries no address, dummy or data bytes and has the flag clear only releases chip select. The position of both SCK edges inside the bit period is programmable in system-clock cycles.

The host side is a plain register port with single-cycle writes and a combinational read. There is no back-pressure on this port: every write takes effect at once. The host must poll the pending status bit before it issues the next command, because a command written while one is still running is refused and flagged as an error. Register select codes: 0 command, 1 address, 2 data, 3 status, 4 timing.

Top module: `sfq_top`

## Requirements
- R1: After reset every cs_n line is high, sck is high, mosi is low, and the command, data and status registers read zero.
- R2: An accepted command puts its bytes on mosi in this order: opcode (command bits 7:0), address, dummy, data. Each byte goes out MSB first. mosi changes only at the start of a bit period, and every bit has exactly one rising edge of sck.
- R3: The address byte count (command bits 22:20) sends that many bytes from the address register, most significant byte first. Values above 4 act as 4.
- R4: The dummy byte count (command bits 19:16, 0 to 15) sends that many all-zero bytes. miso is ignored during dummy bytes.
- R5: A write (command bit 8 set) sends data-register byte k (bits 8k+7:8k) as the k-th data byte, starting at k=0. The data length (command bits 11:9) above 4 acts as 4.
- R6: A read (bit 8 clear) with a nonzero length stores the k-th received byte in data-register bits 8k+7:8k and sets the unused upper bytes to zero. The data register changes only in the cycle in which pending clears. A read of length 0 leaves it unchanged.
- R7: Status bit 22 (pending) is set from the cycle after an accepted command write until the command completes.
- R8: A command write while pending sets status bit 29 (error) and is otherwise ignored. Writing 1 to status bit 29 clears the error bit; writing 0 leaves it as it is.
- R9: A command that starts a transaction drives low only the cs_n line selected by command bits 26:24. If that index is not below NUM_CS, the command sets the error bit and is ignored.
- R10: With the keep flag (command bit 15) set, chip select stays low after completion. The next command continues on the same line, ignores its own index field and omits the opcode.
- R11: With the keep flag clear, chip select is released when pending clears. A continuation with no address, dummy or data bytes produces no sck edge and only releases chip select.
- R12: The timing register gives the period P (bits 3:0, values below 2 act as 2), the rise position R (bits 11:8) and the fall position F (bits 15:12). Each bit lasts P cycles. sck is low from cycle F to cycle R of the period. R is clamped to the range 1 to P-1, and an F not below the clamped R acts as 0.
- R13: Timing values are captured when a command is accepted. Writing the timing register while a command runs has no effect on that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select (0 cmd, 1 addr, 2 data, 3 status, 4 timing) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | NUM_CS | Active-low chip selects |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A wrong phase or byte counter shows on mosi within the same command as a missing, extra or reordered byte, or as a wrong count of sck rising edges. A bad period or edge counter appears at the very next bit as a wrong interval between edges. A stale chip-select hold state shows when the next command completes, because cs_n is then held or released when it should not be, or the opcode is repeated or dropped. A receive path fault shows in the data register readback in the first cycle after pending clears.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_ADDR = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_TIM  = 3'd4;

  localparam int ST_PEND_BIT = 22;
  localparam int ST_ERR_BIT  = 29;
  localparam int MAX_ABYTES  = 4;

  typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;

  // full command word as decoded by the register block
  typedef struct packed {
    logic [2:0] csi;
    logic [2:0] alen;
    logic [3:0] dum;
    logic       keep;
    logic [2:0] dlen;
    logic       wr;
    logic [7:0] opc;
  } cmd_t;

  // the part of a command the shift engine needs
  typedef struct packed {
    logic [7:0] opc;
    logic       wr;
    logic [2:0] dlen;
    logic [3:0] dum;
    logic [2:0] alen;
  } xfer_t;

  typedef struct packed {
    logic [3:0] per;
    logic [3:0] rise;
    logic [3:0] fall;
  } tim_t;

  typedef struct packed {
    logic   ok;
    phase_e ph;
  } pick_t;

  function automatic cmd_t decode_cmd(input logic [REG_W-1:0] w);
    cmd_t c;
    c.opc  = w[7:0];
    c.wr   = w[8];
    c.dlen = w[11:9];
    c.keep = w[15];
    c.dum  = w[19:16];
    c.alen = w[22:20];
    c.csi  = w[26:24];
    return c;
  endfunction

  function automatic logic [2:0] clamp4(input logic [2:0] v);
    return (v > 3'(MAX_ABYTES)) ? 3'(MAX_ABYTES) : v;
  endfunction
endpackage

// File: rtl/sfq_sck_gen.sv
module sfq_sck_gen
  import sfq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  tim_t tim,
  output logic sck,
  output logic sample,
  output logic bit_end
);
  logic [3:0] per_e, rise_e, fall_e, cnt;

  always_comb begin
    per_e  = (tim.per < 4'd2) ? 4'd2 : tim.per;
    if (tim.rise == 4'd0)        rise_e = 4'd1;
    else if (tim.rise >= per_e)  rise_e = per_e - 4'd1;
    else                         rise_e = tim.rise;
    fall_e = (tim.fall >= rise_e) ? 4'd0 : tim.fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!run)                  cnt <= '0;
    else if (cnt == per_e - 4'd1)   cnt <= '0;
    else                            cnt <= cnt + 4'd1;
  end

  assign sck     = !(run && (cnt >= fall_e) && (cnt < rise_e));
  assign sample  = run && (cnt == rise_e);
  assign bit_end = run && (cnt == per_e - 4'd1);

  // R12: the period counter never leaves the programmed period
  p_cnt_in_period_r12: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per_e));
  // R12: the sample point lies strictly after the falling edge
  p_rise_after_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> $past(run) && (cnt > fall_e));
endmodule

// File: rtl/sfq_seq.sv
module sfq_seq
  import sfq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_t       xin,
  input  logic        cont_in,
  input  logic [31:0] addr_in,
  input  logic [31:0] wdata_in,
  input  logic        bit_end,
  input  logic        sample,
  input  logic        miso,
  output logic        run,
  output logic        busy,
  output logic        fin,
  output logic        rx_done,
  output logic        mosi,
  output logic [31:0] rx_data
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_FIN} st_e;

  st_e         st;
  phase_e      phase;
  xfer_t       lx;
  logic        lcont;
  logic [31:0] la, lw, rx_acc;
  logic [3:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic [7:0]  shreg, rxsh, rx_new;
  logic [3:0]  cur_len;
  pick_t       first_pk, nxt_pk;

  function automatic logic [3:0] ph_len(input phase_e ph, input xfer_t c, input logic cont);
    case (ph)
      PH_OPC:   return cont ? 4'd0 : 4'd1;
      PH_ADDR:  return {1'b0, clamp4(c.alen)};
      PH_DUMMY: return c.dum;
      default:  return {1'b0, clamp4(c.dlen)};
    endcase
  endfunction

  function automatic logic [7:0] ph_byte(input phase_e ph, input logic [3:0] idx,
                                         input xfer_t c, input logic [31:0] a,
                                         input logic [31:0] w);
    logic [31:0] t;
    int sh;
    t = '0;
    case (ph)
      PH_OPC:  t = {24'd0, c.opc};
      PH_ADDR: begin
        sh = 8 * (int'(clamp4(c.alen)) - 1 - int'(idx));
        t  = a >> sh;
      end
      PH_DATA: t = c.wr ? (w >> (8 * int'(idx))) : '0;
      default: t = '0;
    endcase
    return t[7:0];
  endfunction

  // lowest phase at or after 'from' that carries bytes
  function automatic pick_t pick(input logic [2:0] from, input xfer_t c, input logic cont);
    pick_t r;
    r = '0;
    for (int p = 3; p >= 0; p--) begin
      if ((p >= int'(from)) && (ph_len(phase_e'(p), c, cont) != 4'd0)) begin
        r.ok = 1'b1;
        r.ph = phase_e'(p);
      end
    end
    return r;
  endfunction

  always_comb begin
    first_pk = pick(3'd0, xin, cont_in);
    nxt_pk   = pick({1'b0, phase} + 3'd1, lx, lcont);
    cur_len  = ph_len(phase, lx, lcont);
    rx_new   = sample ? {rxsh[6:0], miso} : rxsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase    <= PH_OPC;
      lx       <= '0;
      lcont    <= 1'b0;
      la       <= '0;
      lw       <= '0;
      rx_acc   <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      rxsh     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          lx       <= xin;
          lcont    <= cont_in;
          la       <= addr_in;
          lw       <= wdata_in;
          rx_acc   <= '0;
          rxsh     <= '0;
          byte_idx <= '0;
          bit_idx  <= '0;
          if (first_pk.ok) begin
            st    <= S_SHIFT;
            phase <= first_pk.ph;
            shreg <= ph_byte(first_pk.ph, 4'd0, xin, addr_in, wdata_in);
          end else begin
            st <= S_FIN;
          end
        end
        S_SHIFT: begin
          if (sample) rxsh <= rx_new;
          if (bit_end) begin
            if (bit_idx != 3'd7) begin
              bit_idx <= bit_idx + 3'd1;
              shreg   <= {shreg[6:0], 1'b0};
            end else begin
              bit_idx <= '0;
              if (phase == PH_DATA && !lx.wr)
                rx_acc[{byte_idx[1:0], 3'b000} +: 8] <= rx_new;
              if (({1'b0, byte_idx} + 5'd1) < {1'b0, cur_len}) begin
                byte_idx <= byte_idx + 4'd1;
                shreg    <= ph_byte(phase, byte_idx + 4'd1, lx, la, lw);
              end else if (nxt_pk.ok) begin
                phase    <= nxt_pk.ph;
                byte_idx <= '0;
                shreg    <= ph_byte(nxt_pk.ph, 4'd0, lx, la, lw);
              end else begin
                st <= S_FIN;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign run     = (st == S_SHIFT);
  assign busy    = (st != S_IDLE);
  assign fin     = (st == S_FIN);
  assign rx_done = fin && !lx.wr && (lx.dlen != 3'd0);
  assign mosi    = run && shreg[7];
  assign rx_data = rx_acc;

  // R2: mosi only moves at a bit boundary
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_end) |=> $stable(mosi));
  // R4: dummy bytes are all zero on the wire
  p_dummy_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_DUMMY) |-> !mosi);
  // R6: received bytes never exceed the programmed length
  p_rx_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == PH_DATA) |-> (byte_idx < 4'd4));
endmodule

// File: rtl/sfq_top.sv
module sfq_top
  import sfq_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sck,
  output logic [NUM_CS-1:0] cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  cmd_t        cmd_in;
  xfer_t       xin;
  logic [31:0] cmd_r, addr_r, data_r, rx_data;
  tim_t        tim_r, tim_act;
  logic        err_r, cs_held, keep_q;
  logic [CSW-1:0] cs_sel;
  logic        wr_cmd, wr_stat, idx_ok, accept, refuse;
  logic        run, busy, fin, rx_done, bit_end, sample;

  assign cmd_in  = decode_cmd(reg_wdata);
  assign wr_cmd  = reg_we && (reg_addr == A_CMD);
  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign idx_ok  = cs_held || ({29'd0, cmd_in.csi} < NUM_CS);
  assign accept  = wr_cmd && !busy && idx_ok;
  assign refuse  = wr_cmd && !accept;

  always_comb begin
    xin.opc  = cmd_in.opc;
    xin.wr   = cmd_in.wr;
    xin.dlen = cmd_in.dlen;
    xin.dum  = cmd_in.dum;
    xin.alen = cmd_in.alen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r   <= '0;
      addr_r  <= '0;
      data_r  <= '0;
      tim_r   <= '0;
      tim_act <= '0;
      err_r   <= 1'b0;
      cs_held <= 1'b0;
      keep_q  <= 1'b0;
      cs_sel  <= '0;
    end else begin
      if (reg_we && reg_addr == A_ADDR) addr_r <= reg_wdata;
      if (reg_we && reg_addr == A_TIM)
        tim_r <= '{per: reg_wdata[3:0], rise: reg_wdata[11:8], fall: reg_wdata[15:12]};
      if (rx_done)                           data_r <= rx_data;
      else if (reg_we && reg_addr == A_DATA) data_r <= reg_wdata;
      if (refuse)                            err_r <= 1'b1;
      else if (wr_stat && reg_wdata[ST_ERR_BIT]) err_r <= 1'b0;
      if (accept) begin
        cmd_r   <= reg_wdata;
        tim_act <= tim_r;
        keep_q  <= cmd_in.keep;
        if (!cs_held) cs_sel <= CSW'(cmd_in.csi);
      end
      if (fin) cs_held <= keep_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD:  reg_rdata = cmd_r;
      A_ADDR: reg_rdata = addr_r;
      A_DATA: reg_rdata = data_r;
      A_STAT: begin
        reg_rdata[ST_PEND_BIT] = busy;
        reg_rdata[ST_ERR_BIT]  = err_r;
      end
      A_TIM:  reg_rdata = {16'd0, tim_r.fall, tim_r.rise, 4'd0, tim_r.per};
      default: reg_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !((busy || cs_held) && (cs_sel == CSW'(i)));
  end

  sfq_sck_gen u_sck (
    .clk(clk), .rst_n(rst_n), .run(run), .tim(tim_act),
    .sck(sck), .sample(sample), .bit_end(bit_end)
  );

  sfq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .xin(xin), .cont_in(cs_held),
    .addr_in(addr_r), .wdata_in(data_r), .bit_end(bit_end), .sample(sample),
    .miso(miso), .run(run), .busy(busy), .fin(fin), .rx_done(rx_done),
    .mosi(mosi), .rx_data(rx_data)
  );

  // R1: no clock activity while no chip select is low
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> sck);
  // R7: an accepted command is pending in the next cycle
  p_pend_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R8: a command write during a running command raises the error flag
  p_err_on_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd) |=> err_r);
  // R9: at most one chip select active
  p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R9: an out-of-range index on a fresh transaction starts nothing
  p_bad_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy && !cs_held && ({29'd0, cmd_in.csi} >= NUM_CS)) |=> !busy);
  // R6: data register holds still while a command runs
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(reg_we && reg_addr == A_DATA)) |=> ($stable(data_r) || !busy));
endmodule

// File: tb/sfq_top_bench.sv
`timescale 1ns/1ps
module sfq_top_bench;
  localparam int NCS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sck, mosi;
  logic miso_r = 1'b0;
  logic [NCS-1:0] cs_n;

  always #4 clk = ~clk;

  sfq_top #(.NUM_CS(NCS)) u_sfq_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso_r)
  );

  int checks = 0;
  int errors = 0;

  // wire monitor state
  logic mosi_bits [0:1023];
  logic miso_bits [0:1023];
  realtime rise_t [0:1023];
  realtime fall_t [0:1023];
  int nrise = 0, nfall = 0, cs_bad = 0;
  logic [NCS-1:0] exp_csn = '1;

  bit held_m = 1'b0;
  int held_idx = 0;

  initial forever begin
    @(posedge sck);
    if (nrise < 1024) begin
      mosi_bits[nrise] = mosi;
      rise_t[nrise] = $realtime;
      if (cs_n !== exp_csn) cs_bad++;
    end
    nrise++;
  end

  initial forever begin
    @(negedge sck);
    if (nfall < 1024) begin
      miso_r = miso_bits[nfall];
      fall_t[nfall] = $realtime;
    end
    nfall++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int eff_per(input int p);
    return (p < 2) ? 2 : p;
  endfunction
  function automatic int eff_rise(input int r, input int p);
    if (r == 0) return 1;
    if (r >= p) return p - 1;
    return r;
  endfunction

  task automatic do_cmd(input logic [7:0] opc, input bit wrd, input int dlen,
                        input bit keep, input int dum, input int alen,
                        input int csi, input logic [31:0] addr,
                        input logic [31:0] wdata, input int per, input int rise,
                        input int fall, input bit inject, input string req);
    logic [7:0] eb [0:31];
    logic [31:0] s, d, cmdw, dpre, exp_rd;
    int n, ae, de, pe, re, fe, cnt, bad, base, use_idx;
    bit cont;
    n = 0;
    ae = (alen > 4) ? 4 : alen;
    de = (dlen > 4) ? 4 : dlen;
    cont = held_m;
    if (!cont) eb[n++] = opc;
    for (int k = 0; k < ae; k++) eb[n++] = 8'(addr >> (8 * (ae - 1 - k)));
    for (int k = 0; k < dum; k++) eb[n++] = 8'h00;
    for (int k = 0; k < de; k++) eb[n++] = wrd ? 8'(wdata >> (8 * k)) : 8'h00;
    use_idx = cont ? held_idx : csi;
    pe = eff_per(per);
    re = eff_rise(rise, pe);
    fe = (fall >= re) ? 0 : fall;

    dpre = wrd ? wdata : $urandom;
    wr(3'd4, {16'd0, 4'(fall), 4'(rise), 4'd0, 4'(per)});
    wr(3'd1, addr);
    wr(3'd2, dpre);
    for (int i = 0; i < 256; i++) miso_bits[i] = 1'($urandom_range(0, 1));
    nrise = 0; nfall = 0; cs_bad = 0;
    exp_csn = '1;
    exp_csn[use_idx] = 1'b0;
    cmdw = {5'd0, 3'(csi), 1'b0, 3'(alen), 4'(dum), keep, 3'd0, 3'(dlen), wrd, opc};
    wr(3'd0, cmdw);
    rd(3'd3, s);
    check(s[22] == 1'b1, "R7", "pending after command write", s, 32'h0040_0000);
    // R13: retiming in the middle of a command must not matter
    wr(3'd4, {16'd0, 4'(fall + 3), 4'(rise + 5), 4'd0, 4'(per + 7)});
    if (inject) wr(3'd0, {8'h00, 8'h00, 8'h01, 8'hEE});
    cnt = 0;
    rd(3'd3, s);
    while (s[22] && cnt < 5000) begin
      @(negedge clk);
      rd(3'd3, s);
      cnt++;
    end
    check(cnt < 5000, req, "command completes", cnt, 5000);
    check(nrise == 8 * n, req, "sck rising edge count (R2)", nrise, 8 * n);
    bad = 0;
    for (int j = 0; j < n && 8 * j + 7 < nrise; j++) begin
      logic [7:0] got;
      for (int b = 0; b < 8; b++) got[7 - b] = mosi_bits[8 * j + b];
      if (got !== eb[j]) bad++;
    end
    check(bad == 0, req, "mosi byte stream (R2)", bad, 0);
    bad = 0;
    for (int i = 0; i < nrise && i < 256; i++) begin
      if (i > 0 && (rise_t[i] - rise_t[i - 1]) != real'(pe * 8)) bad++;
      if ((rise_t[i] - fall_t[i]) != real'((re - fe) * 8)) bad++;
    end
    check(bad == 0, "R12", "sck period and low window", bad, 0);
    check(cs_bad == 0, "R9", "chip select line during command", cs_bad, 0);
    rd(3'd2, d);
    if (!wrd && de > 0) begin
      exp_rd = '0;
      base = n - de;
      for (int k = 0; k < de; k++)
        for (int b = 0; b < 8; b++)
          exp_rd[8 * k + 7 - b] = miso_bits[8 * (base + k) + b];
      check(d == exp_rd, "R6", "read data register", d, exp_rd);
    end else begin
      check(d == dpre, "R6", "data register unchanged", d, dpre);
    end
    held_m = keep;
    held_idx = use_idx;
    if (keep) check(cs_n == exp_csn, "R10", "cs held after command", cs_n, exp_csn);
    else      check(cs_n == '1, "R11", "cs released after command", cs_n, '1);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cs_n == '1, "R1", "cs_n after reset", cs_n, '1);
    check(sck == 1'b1, "R1", "sck after reset", sck, 1);
    check(mosi == 1'b0, "R1", "mosi after reset", mosi, 0);
    rd(3'd3, s); check(s == 0, "R1", "status after reset", s, 0);
    rd(3'd2, d); check(d == 0, "R1", "data after reset", d, 0);
    rd(3'd0, d); check(d == 0, "R1", "command after reset", d, 0);

    // directed corners
    do_cmd(8'h06, 1'b1, 0, 1'b0, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0, 1'b0, "R12");
    do_cmd(8'h0B, 1'b0, 4, 1'b0, 15, 3, 1, 32'h00A1B2C3, 32'h0, 2, 5, 9, 1'b0, "R4");
    do_cmd(8'h02, 1'b1, 6, 1'b0, 0, 7, 0, 32'h11223344, 32'hDEADBEEF, 15, 9, 3, 1'b0, "R3");
    do_cmd(8'h02, 1'b1, 3, 1'b0, 1, 2, 1, 32'h00005A5A, 32'h00C0FFEE, 3, 2, 1, 1'b0, "R5");
    do_cmd(8'h03, 1'b0, 0, 1'b0, 0, 0, 0, 32'h0, 32'h0, 4, 2, 0, 1'b0, "R6");
    // held transaction: start, continue (index field ignored), release
    do_cmd(8'h03, 1'b0, 0, 1'b1, 0, 3, 1, 32'h00123456, 32'h0, 3, 2, 1, 1'b0, "R10");
    do_cmd(8'h03, 1'b0, 2, 1'b1, 0, 0, 0, 32'h0, 32'h0, 3, 2, 1, 1'b0, "R10");
    do_cmd(8'h03, 1'b0, 0, 1'b0, 0, 0, 0, 32'h0, 32'h0, 3, 2, 1, 1'b0, "R11");
    // refused command during a running one
    do_cmd(8'h9F, 1'b0, 3, 1'b0, 0, 0, 1, 32'h0, 32'h0, 6, 4, 2, 1'b1, "R8");
    rd(3'd3, s); check(s[29] == 1'b1, "R8", "error set by busy write", s, 32'h2000_0000);
    wr(3'd3, 32'h0);
    rd(3'd3, s); check(s[29] == 1'b1, "R8", "writing 0 keeps error", s, 32'h2000_0000);
    wr(3'd3, 32'h2000_0000);
    rd(3'd3, s); check(s[29] == 1'b0, "R8", "writing 1 clears error", s, 0);
    // out-of-range chip select index
    nrise = 0;
    wr(3'd0, {5'd0, 3'd5, 16'd0, 8'hAB});
    rd(3'd3, s);
    check(s[22] == 1'b0 && s[29] == 1'b1, "R9", "bad index refused", s, 32'h2000_0000);
    repeat (20) @(negedge clk);
    check(nrise == 0 && cs_n == '1, "R9", "bad index drives nothing", nrise, 0);
    wr(3'd3, 32'h2000_0000);

    // constrained random commands
    for (int it = 0; it < 30; it++) begin
      do_cmd(8'($urandom), 1'($urandom_range(0, 1)), $urandom_range(0, 5),
             ($urandom_range(0, 3) == 0), $urandom_range(0, 3), $urandom_range(0, 5),
             $urandom_range(0, NCS - 1), $urandom, $urandom,
             $urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 7),
             1'b0, "R2");
    end
    if (held_m)
      do_cmd(8'h00, 1'b0, 0, 1'b0, 0, 0, 0, 32'h0, 32'h0, 2, 1, 0, 1'b0, "R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule